// File: doc/BRIEF.md
# Five-Level Gate Sequencer with Capacitor Balancing

This block drives the ten gate signals of a single-phase, five-level, active neutral-point-clamped bridge. A signed modulation reference is compared against four triangular carriers. The carriers are stacked one above the other and all have the same phase. The number of carriers that the reference exceeds selects one of five output levels: +Vdc, +Vdc/2, 0, −Vdc/2 or −Vdc.

Each half-voltage level can be produced by either of two redundant switching states. One state draws charge from the upper split capacitor and the other from the lower one. The block picks between them using three sign bits: the capacitor voltage difference, the converter output current and the battery current. The aim is to keep the two capacitor voltages equal. When balancing is disabled, a fixed default state is used at each half-voltage level.

The selected state and its ten-bit gate word are registered and change only on a clock edge. The surrounding control loops provide the reference and the measurements. The carrier frequency is set by the parameters. The defaults give about 4.9 kHz at a 200 MHz clock.

Top module: `fl_gate_gen`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 3 and `gate_o` is 10'b0001011110.
- R2: `state_o` codes are: 0 = full positive, 1 = positive-half upper, 2 = positive-half lower, 3 = zero, 4 = negative-half upper, 5 = negative-half lower, 6 = full negative. `gate_o[9:0]` carries switches S1,S3,S5,S7,S9,S2,S4,S6,S8,S10 from bit 9 down to bit 0. The gate words for codes 0 to 6 are 0111010010, 0111010101, 0010011010, 0001011110, 1011001010, 1100101110 and 1001001110.
- R3: A carrier counter starts at 0 and counts upward after reset. It advances by one step every DIV clocks. It reverses at 2^(REF_W-2)−1 and at 0, so its value goes …, MAX−1, MAX, MAX−1, … and …, 1, 0, 1, ….
- R4: Carrier k (k = 0..3) equals −2^(REF_W−1) + k·2^(REF_W−2) + counter. The level L is the number of carriers that the reference strictly exceeds. L = 4 selects code 0, L = 2 selects code 3 and L = 0 selects code 6.
- R5: At L = 3, code 1 is chosen only when balancing is enabled, sign(ΔV) equals sign(ibat) and sign(iout) equals sign(ibat). Otherwise code 2 is chosen.
- R6: At L = 1, code 5 is chosen only when balancing is enabled, sign(ΔV) differs from sign(ibat) and sign(iout) differs from sign(ibat). Otherwise code 4 is chosen.
- R7: With `bal_en_i` low, codes 1 and 5 never appear, whatever the measurement inputs are.
- R8: ΔV, iout and ibat are two's complement, and only their MSB is used. A value of zero counts as non-negative.
- R9: The outputs after a clock edge reflect the inputs and the counter value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | REF_W | Signed modulation reference |
| dv_i | input | MEAS_W | Signed upper minus lower capacitor voltage |
| iout_i | input | MEAS_W | Signed converter output current |
| ibat_i | input | MEAS_W | Signed battery current |
| bal_en_i | input | 1 | Balancing enable |
| gate_o | output | 10 | Registered gate word |
| state_o | output | 3 | Registered switching-state code |

## Verification
Two events can land on the same edge. The first is the carrier counter turning a level crossing. The second is a change of balance inputs that flips the redundant-state choice. To provoke this, the bench holds or ramps the reference near a carrier band. At the same time it randomises the enable and the three sign inputs on every cycle. A behavioural model tracks the counter with plain integers and predicts both the level and the redundant choice for each edge. The registered state code and gate word are compared against this prediction after every edge.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [2:0] {
    ST_P_FULL = 3'd0,
    ST_P_HI   = 3'd1,
    ST_P_LO   = 3'd2,
    ST_ZERO   = 3'd3,
    ST_N_HI   = 3'd4,
    ST_N_LO   = 3'd5,
    ST_N_FULL = 3'd6
  } sw_state_e;

  // bit 9..0 = S1,S3,S5,S7,S9,S2,S4,S6,S8,S10
  function automatic logic [9:0] gate_word(sw_state_e s);
    case (s)
      ST_P_FULL: gate_word = 10'b0111010010;
      ST_P_HI:   gate_word = 10'b0111010101;
      ST_P_LO:   gate_word = 10'b0010011010;
      ST_ZERO:   gate_word = 10'b0001011110;
      ST_N_HI:   gate_word = 10'b1011001010;
      ST_N_LO:   gate_word = 10'b1100101110;
      ST_N_FULL: gate_word = 10'b1001001110;
      default:   gate_word = 10'b0001011110;
    endcase
  endfunction
endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
  parameter int CNT_W = 12,
  parameter int DIV   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DW-1:0]    div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             tick;

  assign tick = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (up_q) begin
          if (cnt_q == CNT_MAX) begin
            cnt_q <= cnt_q - 1'b1;
            up_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_q <= cnt_q + 1'b1;
            up_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o = cnt_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ((CNT_W'(cnt_q - $past(cnt_q)) == CNT_W'(1)) ||
              (CNT_W'($past(cnt_q) - cnt_q) == CNT_W'(1))));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/fl_level.sv
module fl_level #(
  parameter int REF_W = 14
) (
  input  logic [REF_W-1:0] ref_i,
  input  logic [REF_W-3:0] cnt_i,
  output logic [2:0]       level_o
);
  localparam int BAND   = 2 ** (REF_W - 2);
  localparam int HALF   = 2 ** (REF_W - 1);
  localparam int NCAR   = 4;
  localparam int XW     = REF_W + 2;

  logic signed [XW-1:0] ref_x;
  logic [NCAR-1:0]      above;

  assign ref_x = $signed({{2{ref_i[REF_W-1]}}, ref_i});

  for (genvar g = 0; g < NCAR; g++) begin : g_car
    logic signed [XW-1:0] car;
    assign car = $signed(XW'(g * BAND - HALF)) + $signed({4'b0000, cnt_i});
    assign above[g] = (ref_x > car);
  end

  assign level_o = 3'($countones(above));
endmodule

// File: rtl/fl_select.sv
module fl_select
  import fl_pkg::*;
#(
  parameter int MEAS_W = 16
) (
  input  logic [2:0]        level_i,
  input  logic [MEAS_W-1:0] dv_i,
  input  logic [MEAS_W-1:0] iout_i,
  input  logic [MEAS_W-1:0] ibat_i,
  input  logic              en_i,
  output sw_state_e         state_o
);
  logic dv_neg, io_neg, ib_neg;
  logic pick_p_hi, pick_n_lo;

  assign dv_neg = dv_i[MEAS_W-1];
  assign io_neg = iout_i[MEAS_W-1];
  assign ib_neg = ibat_i[MEAS_W-1];

  // sign of product >= 0 <=> sign bits agree
  assign pick_p_hi = en_i && (dv_neg == ib_neg) && (io_neg == ib_neg);
  assign pick_n_lo = en_i && (dv_neg != ib_neg) && (io_neg != ib_neg);

  always_comb begin
    case (level_i)
      3'd4:    state_o = ST_P_FULL;
      3'd3:    state_o = pick_p_hi ? ST_P_HI : ST_P_LO;
      3'd2:    state_o = ST_ZERO;
      3'd1:    state_o = pick_n_lo ? ST_N_LO : ST_N_HI;
      default: state_o = ST_N_FULL;
    endcase
  end
endmodule

// File: rtl/fl_gate_gen.sv
module fl_gate_gen
  import fl_pkg::*;
#(
  parameter int REF_W  = 14,
  parameter int MEAS_W = 16,
  parameter int DIV    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [MEAS_W-1:0] dv_i,
  input  logic [MEAS_W-1:0] iout_i,
  input  logic [MEAS_W-1:0] ibat_i,
  input  logic              bal_en_i,
  output logic [9:0]        gate_o,
  output logic [2:0]        state_o
);
  localparam int CNT_W = REF_W - 2;

  logic [CNT_W-1:0] cnt;
  logic [2:0]       level;
  sw_state_e        nxt_state, state_q;
  logic [9:0]       gate_q;

  fl_carrier #(.CNT_W(CNT_W), .DIV(DIV)) u_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  fl_level #(.REF_W(REF_W)) u_level (
    .ref_i   (ref_i),
    .cnt_i   (cnt),
    .level_o (level)
  );

  fl_select #(.MEAS_W(MEAS_W)) u_select (
    .level_i (level),
    .dv_i    (dv_i),
    .iout_i  (iout_i),
    .ibat_i  (ibat_i),
    .en_i    (bal_en_i),
    .state_o (nxt_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ZERO;
      gate_q  <= gate_word(ST_ZERO);
    end else begin
      state_q <= nxt_state;
      gate_q  <= gate_word(nxt_state);
    end
  end

  assign gate_o  = gate_q;
  assign state_o = state_q;

  p_bal_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bal_en_i |=> (state_q != ST_P_HI) && (state_q != ST_N_LO));

  p_half_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level == 3'd3) |=> (state_q == ST_P_HI) || (state_q == ST_P_LO));

  p_neg_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level == 3'd1) |=> (state_q == ST_N_HI) || (state_q == ST_N_LO));

  p_s1_neg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q[9] |-> (state_q == ST_N_HI) || (state_q == ST_N_LO) || (state_q == ST_N_FULL));

  p_weight_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(gate_q) >= 4) && ($countones(gate_q) <= 6));
endmodule

// File: tb/tb_fl_gate_gen.sv
`timescale 1ns/1ps
module tb_fl_gate_gen;
  localparam int REF_W  = 8;
  localparam int MEAS_W = 12;
  localparam int DIV    = 2;
  localparam int BAND   = 2 ** (REF_W - 2);
  localparam int HALF   = 2 ** (REF_W - 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [REF_W-1:0]  ref_s  = '0;
  logic signed [MEAS_W-1:0] dv_s   = '0;
  logic signed [MEAS_W-1:0] io_s   = '0;
  logic signed [MEAS_W-1:0] ib_s   = '0;
  logic bal_en = 1'b0;
  logic [9:0] gate_o;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  int mcnt = 0, mup = 1, mdiv = 0;
  int exp_st = 3;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fl_gate_gen #(.REF_W(REF_W), .MEAS_W(MEAS_W), .DIV(DIV)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .ref_i    (ref_s),
    .dv_i     (dv_s),
    .iout_i   (io_s),
    .ibat_i   (ib_s),
    .bal_en_i (bal_en),
    .gate_o   (gate_o),
    .state_o  (state_o)
  );

  function automatic int model_state(int r, int dv, int io, int ib, bit en, int c);
    int lvl = 0;
    for (int k = 0; k < 4; k++) if (r > -HALF + k * BAND + c) lvl++;
    case (lvl)
      4: return 0;
      3: return (en && ((dv < 0) == (ib < 0)) && ((io < 0) == (ib < 0))) ? 1 : 2;
      2: return 3;
      1: return (en && ((dv < 0) != (ib < 0)) && ((io < 0) != (ib < 0))) ? 5 : 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [9:0] model_gate(int s);
    case (s)
      0: return 10'b0111010010;
      1: return 10'b0111010101;
      2: return 10'b0010011010;
      3: return 10'b0001011110;
      4: return 10'b1011001010;
      5: return 10'b1100101110;
      default: return 10'b1001001110;
    endcase
  endfunction

  function automatic string auto_tag(int s);
    if (s == 1 || s == 2) return "R5";
    if (s == 4 || s == 5) return "R6";
    return "R4";
  endfunction

  task automatic advance_model();
    if (mdiv == DIV - 1) begin
      mdiv = 0;
      if (mup != 0) begin
        if (mcnt == BAND - 1) begin mcnt--; mup = 0; end else mcnt++;
      end else begin
        if (mcnt == 0) begin mcnt++; mup = 1; end else mcnt--;
      end
    end else begin
      mdiv++;
    end
  endtask

  task automatic check_out(string tag);
    string t;
    t = (tag == "") ? auto_tag(exp_st) : tag;
    checks++;
    if (int'(state_o) != exp_st) begin
      errors++;
      $display("FAIL %s state: actual %0d expected %0d (R9 timing)", t, state_o, exp_st);
    end
    checks++;
    if (gate_o !== model_gate(exp_st)) begin
      errors++;
      $display("FAIL R2 gate: actual %b expected %b", gate_o, model_gate(exp_st));
    end
  endtask

  task automatic drive(int r, int dv, int io, int ib, bit en);
    ref_s  = REF_W'(r);
    dv_s   = MEAS_W'(dv);
    io_s   = MEAS_W'(io);
    ib_s   = MEAS_W'(ib);
    bal_en = en;
    exp_st = model_state(int'(ref_s), int'(dv_s), int'(io_s), int'(ib_s), en, mcnt);
    advance_model();
  endtask

  task automatic cycle(string tag, int r, int dv, int io, int ib, bit en);
    @(negedge clk);
    check_out(tag);
    drive(r, dv, io, ib, en);
  endtask

  function automatic int rnd_meas();
    return int'($signed(MEAS_W'($urandom)));
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (state_o !== 3'd3 || gate_o !== 10'b0001011110) begin
      errors++;
      $display("FAIL R1 reset: actual %0d/%b expected 3/0001011110", state_o, gate_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    drive(0, 0, 0, 0, 1'b0);

    // R4: slow ramp across the full reference range, balancing random
    for (int i = 0; i < 2000; i++)
      cycle("", -HALF + (i * 2 * HALF) / 2000, rnd_meas(), rnd_meas(), rnd_meas(), 1'($urandom));

    // R5/R6/R9: everything random every cycle
    for (int i = 0; i < 2000; i++)
      cycle("", int'($signed(REF_W'($urandom))), rnd_meas(), rnd_meas(), rnd_meas(),
            ($urandom % 4) != 0);

    // R7: balancing off
    for (int i = 0; i < 800; i++)
      cycle("R7", int'($signed(REF_W'($urandom))), rnd_meas(), rnd_meas(), rnd_meas(), 1'b0);

    // R8: zero measurements count as non-negative
    for (int i = 0; i < 400; i++) begin
      int ib;
      case (i % 3)
        0: ib = 0;
        1: ib = -1;
        default: ib = 5;
      endcase
      cycle("R8", int'($signed(REF_W'($urandom))), ((i / 3) % 2 == 0) ? 0 : -1,
            ((i / 6) % 2 == 0) ? 0 : -3, ib, 1'b1);
    end

    // R3: reference parked inside one band, level follows the counter
    for (int i = 0; i < 600; i++)
      cycle("R3", -HALF + BAND + BAND / 2, rnd_meas(), rnd_meas(), rnd_meas(), 1'($urandom));

    @(negedge clk);
    check_out("R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule